// File: doc/BRIEF.md
# Burst transmit FIFO controller

This block buffers I/Q sample pairs between a data source and a symbol-rate consumer. Each accepted input pair is stored as one word, with I in the upper half and Q in the lower half. Stored words are handed out one per symbol tick. The symbol tick is independent of the write strobe, so the producer and the consumer may run at different rates. When the consumer is idle the output can either hold its last value or drop to zero. A gated mode lets a burst be loaded first and sent later under a transmit-enable input. For such a burst the read position can be rewound to location zero, so the stored words are replayed from the start.

Configuration inputs select the following:

- free-running or gated reads;
- zero-fill of idle symbols;
- whether writes are dropped or overwrite the oldest entry when the store is full;
- rewind or resume at the start of each gated burst;
- a bypass path that sends each input pair straight to the output register.

Two fill-level compare outputs are provided against programmable marks. Overflow and underflow events are reported as one-cycle pulses.

Top module: `burst_tx_fifo`

## Requirements
- R1: While reset is asserted, level is 0, empty is 1, full is 0, and out_i, out_q, out_valid, ovf_pulse and unf_pulse are all 0.
- R2: An accepted write stores {wr_i, wr_q} and raises level by one in the next cycle. Full is 1 exactly when level equals DEPTH, empty is 1 exactly when level is 0, and level never exceeds DEPTH.
- R3: When a write and a read happen in the same cycle, level is unchanged, and words leave in the order they were written.
- R4: With cfg_gated=0, no read happens until level has reached 2. From then on, each sym_tick with data present puts the oldest word on out_i/out_q and raises out_valid for one cycle, one cycle after the tick. An underflow stops reading until level is 2 again.
- R5: With cfg_gated=1, reads happen only on ticks while tx_en=1. No read happens in the first cycle in which tx_en is seen high.
- R6: On a sym_tick that reads nothing, out_i and out_q become 0 when cfg_zero_fill=1 and keep their value when cfg_zero_fill=0.
- R7: While full, with cfg_block_full=1, a write is discarded. With cfg_block_full=0, the write replaces the oldest word, which is lost, and level stays at DEPTH.
- R8: When tx_en rises in gated mode with cfg_restart_zero=1, the read address returns to 0. Level becomes the write address, plus one if a write is accepted in that cycle. With cfg_restart_zero=0, the read address continues from where it stopped.
- R9: With cfg_bypass=1, a write appears on out_i/out_q with out_valid=1 one cycle later. Storage and level are untouched, and sym_tick has no effect.
- R10: above_hi is 1 exactly when level >= cfg_hi_thr, and below_lo is 1 exactly when level <= cfg_lo_thr.
- R11: ovf_pulse is 1 for one cycle after any write attempt while full, outside bypass.
- R12: unf_pulse is 1 for one cycle after a read-eligible sym_tick while empty, outside bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Input pair valid strobe |
| wr_i | input | W | In-phase input sample |
| wr_q | input | W | Quadrature input sample |
| sym_tick | input | 1 | Symbol-rate read tick |
| tx_en | input | 1 | Transmit enable for gated reads |
| cfg_gated | input | 1 | 1 = reads gated by tx_en |
| cfg_zero_fill | input | 1 | 1 = zero output on ticks without a read |
| cfg_block_full | input | 1 | 1 = drop writes while full |
| cfg_restart_zero | input | 1 | 1 = rewind read address at start of each gated burst |
| cfg_bypass | input | 1 | 1 = input pair goes straight to the output |
| cfg_hi_thr | input | LW | High fill mark |
| cfg_lo_thr | input | LW | Low fill mark |
| out_i | output | W | In-phase output sample |
| out_q | output | W | Quadrature output sample |
| out_valid | output | 1 | Output word updated with data this cycle |
| level | output | LW | Current number of stored words |
| full | output | 1 | level equals DEPTH |
| empty | output | 1 | level is 0 |
| above_hi | output | 1 | level >= cfg_hi_thr |
| below_lo | output | 1 | level <= cfg_lo_thr |
| ovf_pulse | output | 1 | One-cycle overflow event |
| unf_pulse | output | 1 | One-cycle underflow event |

## Verification
The bench runs a small store through every combination of the four mode bits, plus bypass switched on and off while words are held. It drives it with write-heavy, tick-heavy and mixed traffic, so that full, overwrite, underflow and replay all occur many times.

Several faults would show up at the ports:

- A read and a write colliding at the full or empty boundary: a wrong count would make level drift or wrap past DEPTH.
- A free-running read started on the first word instead of the second: a word would leave one tick early.
- A rewind that ignored a write in the same cycle: one word of the replayed burst would be lost.
- An overwrite that did not advance the read address: a stale word would be handed out.

// File: rtl/btx_pkg.sv
`timescale 1ns/1ps
package btx_pkg;

   // How the fill count moves in a given cycle
   typedef enum logic [1:0] {
      LVL_HOLD = 2'd0,
      LVL_INC  = 2'd1,
      LVL_DEC  = 2'd2,
      LVL_LOAD = 2'd3
   } lvl_op_e;

   // Bits needed to hold a count from 0 to depth inclusive
   function automatic int lvl_bits(input int depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/btx_store.sv
`timescale 1ns/1ps
// Word storage: one synchronous write port, one asynchronous read port
module btx_store #(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int NWORDS = 2 ** AW;

   logic [DW-1:0] mem [NWORDS];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/btx_ptrs.sv
`timescale 1ns/1ps
// Address, fill-count and read-permission logic
module btx_ptrs
   import btx_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int AW    = 8,
   parameter int LW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          byp,
   input  logic          wr_valid,
   input  logic          sym_tick,
   input  logic          tx_en,
   input  logic          cfg_gated,
   input  logic          cfg_block_full,
   input  logic          cfg_restart_zero,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic          wr_fire,
   output logic          rd_fire,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty,
   output logic          ovf,
   output logic          unf
);

   localparam logic [LW-1:0] LVL_FULL  = LW'(DEPTH);
   localparam logic [LW-1:0] LVL_PRIME = LW'(2);

   logic          tx_q;
   logic          run_q;
   logic          ovf_q;
   logic          unf_q;
   logic [AW-1:0] wa_q;
   logic [AW-1:0] ra_q;
   logic [LW-1:0] cnt_q;

   logic    full_c;
   logic    empty_c;
   logic    start_c;
   logic    rewind_c;
   logic    elig_c;
   logic    rd_c;
   logic    unf_c;
   logic    wr_c;
   logic    ovw_c;
   lvl_op_e op_c;

   always_comb begin
      full_c   = (cnt_q == LVL_FULL);
      empty_c  = (cnt_q == '0);
      start_c  = cfg_gated && tx_en && !tx_q;
      rewind_c = start_c && cfg_restart_zero && !byp;
      elig_c   = cfg_gated ? (tx_en && !start_c) : run_q;
      rd_c     = !byp && sym_tick && elig_c && !empty_c;
      unf_c    = !byp && sym_tick && elig_c && empty_c;
      wr_c     = !byp && wr_valid && !(full_c && cfg_block_full);
      ovw_c    = wr_c && full_c && !rd_c && !rewind_c;
      if (rewind_c) begin
         op_c = LVL_LOAD;
      end else if (ovw_c) begin
         op_c = LVL_HOLD;
      end else if (wr_c && !rd_c) begin
         op_c = LVL_INC;
      end else if (rd_c && !wr_c) begin
         op_c = LVL_DEC;
      end else begin
         op_c = LVL_HOLD;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q  <= 1'b0;
         run_q <= 1'b0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
         wa_q  <= '0;
         ra_q  <= '0;
         cnt_q <= '0;
      end else begin
         tx_q  <= tx_en;
         ovf_q <= !byp && wr_valid && full_c;
         unf_q <= unf_c;
         if (unf_c) begin
            run_q <= 1'b0;
         end else if (cnt_q >= LVL_PRIME) begin
            run_q <= 1'b1;
         end
         if (wr_c) begin
            wa_q <= wa_q + AW'(1);
         end
         if (rewind_c) begin
            ra_q <= '0;
         end else if (rd_c || ovw_c) begin
            ra_q <= ra_q + AW'(1);
         end
         unique case (op_c)
            LVL_INC:  cnt_q <= cnt_q + LW'(1);
            LVL_DEC:  cnt_q <= cnt_q - LW'(1);
            LVL_LOAD: cnt_q <= LW'(wa_q) + LW'(wr_c);
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   assign wr_addr = wa_q;
   assign rd_addr = ra_q;
   assign wr_fire = wr_c;
   assign rd_fire = rd_c;
   assign level   = cnt_q;
   assign full    = full_c;
   assign empty   = empty_c;
   assign ovf     = ovf_q;
   assign unf     = unf_q;

endmodule

// File: rtl/btx_outreg.sv
`timescale 1ns/1ps
// Output word register: stored read data, zero fill, or bypassed input
module btx_outreg #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          byp,
   input  logic          wr_valid,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_fire,
   input  logic [DW-1:0] rd_data,
   input  logic          sym_tick,
   input  logic          zero_fill,
   output logic [DW-1:0] out_data,
   output logic          out_valid
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_data  <= '0;
         out_valid <= 1'b0;
      end else if (byp) begin
         out_valid <= wr_valid;
         if (wr_valid) begin
            out_data <= wr_data;
         end
      end else begin
         out_valid <= rd_fire;
         if (rd_fire) begin
            out_data <= rd_data;
         end else if (sym_tick && zero_fill) begin
            out_data <= '0;
         end
      end
   end

endmodule

// File: rtl/burst_tx_fifo.sv
`timescale 1ns/1ps
module burst_tx_fifo
   import btx_pkg::*;
#(
   parameter int DEPTH      = 256,
   parameter int W          = 16,
   parameter int HAS_BYPASS = 1,
   localparam int AW        = $clog2(DEPTH),
   localparam int LW        = lvl_bits(DEPTH),
   localparam int DW        = 2 * W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic [W-1:0]  wr_i,
   input  logic [W-1:0]  wr_q,
   input  logic          sym_tick,
   input  logic          tx_en,
   input  logic          cfg_gated,
   input  logic          cfg_zero_fill,
   input  logic          cfg_block_full,
   input  logic          cfg_restart_zero,
   input  logic          cfg_bypass,
   input  logic [LW-1:0] cfg_hi_thr,
   input  logic [LW-1:0] cfg_lo_thr,
   output logic [W-1:0]  out_i,
   output logic [W-1:0]  out_q,
   output logic          out_valid,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty,
   output logic          above_hi,
   output logic          below_lo,
   output logic          ovf_pulse,
   output logic          unf_pulse
);

   // Elaboration-time parameter checks
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("burst_tx_fifo: DEPTH must be a power of two and at least 4");
   end
   if (W < 1 || W > 16) begin : g_bad_width
      $error("burst_tx_fifo: W must lie between 1 and 16");
   end

   logic          byp;
   logic [AW-1:0] wr_addr;
   logic [AW-1:0] rd_addr;
   logic          wr_fire;
   logic          rd_fire;
   logic [DW-1:0] rd_data;
   logic [DW-1:0] out_data;
   logic [DW-1:0] in_data;

   if (HAS_BYPASS != 0) begin : g_byp
      assign byp = cfg_bypass;
   end else begin : g_no_byp
      assign byp = 1'b0;
   end

   assign in_data = {wr_i, wr_q};

   btx_ptrs #(
      .DEPTH(DEPTH),
      .AW   (AW),
      .LW   (LW)
   ) u_ptrs (
      .clk             (clk),
      .rst_n           (rst_n),
      .byp             (byp),
      .wr_valid        (wr_valid),
      .sym_tick        (sym_tick),
      .tx_en           (tx_en),
      .cfg_gated       (cfg_gated),
      .cfg_block_full  (cfg_block_full),
      .cfg_restart_zero(cfg_restart_zero),
      .wr_addr         (wr_addr),
      .rd_addr         (rd_addr),
      .wr_fire         (wr_fire),
      .rd_fire         (rd_fire),
      .level           (level),
      .full            (full),
      .empty           (empty),
      .ovf             (ovf_pulse),
      .unf             (unf_pulse)
   );

   btx_store #(
      .AW(AW),
      .DW(DW)
   ) u_store (
      .clk  (clk),
      .we   (wr_fire),
      .waddr(wr_addr),
      .wdata(in_data),
      .raddr(rd_addr),
      .rdata(rd_data)
   );

   btx_outreg #(
      .DW(DW)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .byp      (byp),
      .wr_valid (wr_valid),
      .wr_data  (in_data),
      .rd_fire  (rd_fire),
      .rd_data  (rd_data),
      .sym_tick (sym_tick),
      .zero_fill(cfg_zero_fill),
      .out_data (out_data),
      .out_valid(out_valid)
   );

   assign out_i    = out_data[DW-1:W];
   assign out_q    = out_data[W-1:0];
   assign above_hi = (level >= cfg_hi_thr);
   assign below_lo = (level <= cfg_lo_thr);

endmodule

// File: rtl/btx_chk.sv
`timescale 1ns/1ps
module btx_chk #(
   parameter int DEPTH      = 256,
   parameter int W          = 16,
   parameter int HAS_BYPASS = 1,
   parameter int LW         = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_valid,
   input logic [W-1:0]  wr_i,
   input logic [W-1:0]  wr_q,
   input logic          sym_tick,
   input logic          tx_en,
   input logic          cfg_gated,
   input logic          cfg_zero_fill,
   input logic          cfg_block_full,
   input logic          cfg_bypass,
   input logic [W-1:0]  out_i,
   input logic [W-1:0]  out_q,
   input logic          out_valid,
   input logic [LW-1:0] level,
   input logic          full,
   input logic          empty,
   input logic          ovf_pulse,
   input logic          unf_pulse
);

   localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

   // R2
   level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_MAX);

   // R3
   same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bypass && cfg_gated && tx_en && $past(tx_en) && $past(rst_n)
       && sym_tick && wr_valid && !full && !empty) |=> $stable(level));

   // R5
   gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bypass && cfg_gated && !tx_en && sym_tick) |=> !out_valid);

   // R6
   zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bypass && cfg_zero_fill && sym_tick && empty)
      |=> (out_i == '0 && out_q == '0));

   // R7
   block_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bypass && cfg_block_full && full && wr_valid && !sym_tick && !tx_en)
      |=> (full && $stable(level)));

   // R9
   bypass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_BYPASS != 0 && cfg_bypass && wr_valid)
      |=> (out_valid && out_i == $past(wr_i) && out_q == $past(wr_q)));

   // R9
   bypass_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_BYPASS != 0 && cfg_bypass) |=> $stable(level));

   // R11
   ovf_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bypass && wr_valid && full) |=> ovf_pulse);

   // R12
   unf_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bypass && cfg_gated && tx_en && $past(tx_en) && $past(rst_n)
       && sym_tick && empty) |=> unf_pulse);

endmodule

bind burst_tx_fifo btx_chk #(
   .DEPTH     (DEPTH),
   .W         (W),
   .HAS_BYPASS(HAS_BYPASS),
   .LW        (LW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_valid      (wr_valid),
   .wr_i          (wr_i),
   .wr_q          (wr_q),
   .sym_tick      (sym_tick),
   .tx_en         (tx_en),
   .cfg_gated     (cfg_gated),
   .cfg_zero_fill (cfg_zero_fill),
   .cfg_block_full(cfg_block_full),
   .cfg_bypass    (cfg_bypass),
   .out_i         (out_i),
   .out_q         (out_q),
   .out_valid     (out_valid),
   .level         (level),
   .full          (full),
   .empty         (empty),
   .ovf_pulse     (ovf_pulse),
   .unf_pulse     (unf_pulse)
);

// File: tb/tb_burst_tx_fifo.sv
`timescale 1ns/1ps
module tb_burst_tx_fifo;

   localparam int DEPTH = 8;
   localparam int W     = 4;
   localparam int LW    = $clog2(DEPTH + 1);
   localparam int DW    = 2 * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [W-1:0]  wr_i = '0;
   logic [W-1:0]  wr_q = '0;
   logic          sym_tick = 1'b0;
   logic          tx_en = 1'b0;
   logic          cfg_gated = 1'b0;
   logic          cfg_zero_fill = 1'b0;
   logic          cfg_block_full = 1'b0;
   logic          cfg_restart_zero = 1'b0;
   logic          cfg_bypass = 1'b0;
   logic [LW-1:0] cfg_hi_thr = '0;
   logic [LW-1:0] cfg_lo_thr = '0;
   logic [W-1:0]  out_i;
   logic [W-1:0]  out_q;
   logic          out_valid;
   logic [LW-1:0] level;
   logic          full;
   logic          empty;
   logic          above_hi;
   logic          below_lo;
   logic          ovf_pulse;
   logic          unf_pulse;

   burst_tx_fifo #(
      .DEPTH     (DEPTH),
      .W         (W),
      .HAS_BYPASS(1)
   ) dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .wr_valid        (wr_valid),
      .wr_i            (wr_i),
      .wr_q            (wr_q),
      .sym_tick        (sym_tick),
      .tx_en           (tx_en),
      .cfg_gated       (cfg_gated),
      .cfg_zero_fill   (cfg_zero_fill),
      .cfg_block_full  (cfg_block_full),
      .cfg_restart_zero(cfg_restart_zero),
      .cfg_bypass      (cfg_bypass),
      .cfg_hi_thr      (cfg_hi_thr),
      .cfg_lo_thr      (cfg_lo_thr),
      .out_i           (out_i),
      .out_q           (out_q),
      .out_valid       (out_valid),
      .level           (level),
      .full            (full),
      .empty           (empty),
      .above_hi        (above_hi),
      .below_lo        (below_lo),
      .ovf_pulse       (ovf_pulse),
      .unf_pulse       (unf_pulse)
   );

   always #5 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Behavioural expectation of the store, built from the requirements
   logic [DW-1:0] m_mem [DEPTH];
   int            m_wa, m_ra, m_cnt;
   bit            m_run, m_txq, m_ov, m_ovf, m_unf;
   logic [DW-1:0] m_out;
   string         t_lvl, t_out;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk(t_lvl, "level", int'(level), m_cnt);
      chk(t_lvl, "full", int'(full), int'(m_cnt == DEPTH));
      chk(t_lvl, "empty", int'(empty), int'(m_cnt == 0));
      chk(t_out, "out_valid", int'(out_valid), int'(m_ov));
      chk(t_out, "out_i", int'(out_i), int'(m_out[DW-1:W]));
      chk(t_out, "out_q", int'(out_q), int'(m_out[W-1:0]));
      chk("R11", "ovf_pulse", int'(ovf_pulse), int'(m_ovf));
      chk("R12", "unf_pulse", int'(unf_pulse), int'(m_unf));
      chk("R10", "above_hi", int'(above_hi), int'(m_cnt >= int'(cfg_hi_thr)));
      chk("R10", "below_lo", int'(below_lo), int'(m_cnt <= int'(cfg_lo_thr)));
   endtask

   task automatic model_reset();
      m_wa = 0; m_ra = 0; m_cnt = 0;
      m_run = 0; m_txq = 0; m_ov = 0; m_ovf = 0; m_unf = 0;
      m_out = '0;
      t_lvl = "R1"; t_out = "R1";
   endtask

   // Advance the expectation by one clock edge using the inputs now driven
   task automatic model_step();
      bit is_full, is_empty, start, rewind, elig, rd, unf, wdo, ovw;
      is_full  = (m_cnt == DEPTH);
      is_empty = (m_cnt == 0);
      if (cfg_bypass) begin
         m_ov  = wr_valid;
         if (wr_valid) m_out = {wr_i, wr_q};
         m_ovf = 0;
         m_unf = 0;
         t_out = "R9";
         t_lvl = "R9";
      end else begin
         start  = cfg_gated && tx_en && !m_txq;
         rewind = start && cfg_restart_zero;
         elig   = cfg_gated ? (tx_en && !start) : m_run;
         rd     = sym_tick && elig && !is_empty;
         unf    = sym_tick && elig && is_empty;
         wdo    = wr_valid && !(is_full && cfg_block_full);
         ovw    = wdo && is_full && !rd && !rewind;
         m_ovf  = wr_valid && is_full;
         m_unf  = unf;
         m_ov   = rd;
         if (rd) m_out = m_mem[m_ra];
         else if (sym_tick && cfg_zero_fill) m_out = '0;
         if (sym_tick && !rd && cfg_zero_fill) t_out = "R6";
         else t_out = cfg_gated ? "R5" : "R4";
         if (start) t_lvl = "R8";
         else if (wr_valid && is_full) t_lvl = "R7";
         else if (wdo && rd) t_lvl = "R3";
         else t_lvl = "R2";
         if (unf) m_run = 0;
         else if (m_cnt >= 2) m_run = 1;
         if (rewind) m_cnt = m_wa + int'(wdo);
         else if (!ovw) m_cnt = m_cnt + int'(wdo) - int'(rd);
         if (rewind) m_ra = 0;
         else if (rd || ovw) m_ra = (m_ra + 1) % DEPTH;
         if (wdo) begin
            m_mem[m_wa] = {wr_i, wr_q};
            m_wa = (m_wa + 1) % DEPTH;
         end
      end
      if (!cfg_bypass && m_cnt >= 2 && !m_unf) m_run = m_run;
      m_txq = tx_en;
   endtask

   task automatic drive_random(input int wr_pct, input int tick_pct);
      wr_valid   = ($urandom_range(99) < wr_pct);
      sym_tick   = ($urandom_range(99) < tick_pct);
      wr_i       = W'($urandom_range(2 ** W - 1));
      wr_q       = W'($urandom_range(2 ** W - 1));
      cfg_hi_thr = LW'($urandom_range(DEPTH));
      cfg_lo_thr = LW'($urandom_range(DEPTH));
      if ($urandom_range(9) == 0) tx_en = !tx_en;
   endtask

   task automatic do_reset();
      rst_n    = 1'b0;
      wr_valid = 1'b0;
      sym_tick = 1'b0;
      tx_en    = 1'b0;
      repeat (2) @(negedge clk);
      model_reset();
      // R1: state held in reset
      compare();
      rst_n = 1'b1;
   endtask

   initial begin
      // Sweep all mode combinations with write-heavy, tick-heavy and mixed traffic
      for (int c = 0; c < 16; c++) begin
         cfg_gated        = c[0];
         cfg_zero_fill    = c[1];
         cfg_block_full   = c[2];
         cfg_restart_zero = c[3];
         cfg_bypass       = 1'b0;
         do_reset();
         for (int k = 0; k < 480; k++) begin
            case (k / 120)
               0:       drive_random(80, 15);
               1:       drive_random(15, 75);
               default: drive_random(50, 50);
            endcase
            model_step();
            @(negedge clk);
            compare();
         end
      end
      // Bypass switched in and out while words are held (R9)
      do_reset();
      for (int k = 0; k < 1200; k++) begin
         if (k % 60 == 0) begin
            cfg_bypass       = ($urandom_range(2) == 0);
            cfg_gated        = ($urandom_range(1) == 1);
            cfg_zero_fill    = ($urandom_range(1) == 1);
            cfg_block_full   = ($urandom_range(1) == 1);
            cfg_restart_zero = ($urandom_range(1) == 1);
         end
         drive_random(45, 45);
         model_step();
         @(negedge clk);
         compare();
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule